// File: doc/BRIEF.md
# Shift Microoperation Register

This block is a clocked register of parameterised width that performs one single-place shift operation per clock when its enable is high. It offers logical, rotating and sign-keeping arithmetic shifts in both directions, and also a parallel load and a hold. The contents are taken as two's-complement numbers, with the sign in the top bit. An operation code picks the action, and the block applies it at the rising clock edge.

When an arithmetic left shift changes the sign bit, the block raises a registered overflow flag. Because the flag is held, it stays readable after the result has been stored. It is used as the shifting stage in a datapath that steps one place per cycle.

Top module: `shift_uop_reg`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) clears the register to zero and clears the overflow flag.
- R2: When en is low, the register and the flag keep their values whatever the op code is. Op 3'b000 (hold) with en high also keeps the register, and it clears the flag.
- R3: Op 3'b001 (load) with en high stores load_data into the register.
- R4: Op 3'b010 (logical left) moves every bit up one place, puts 0 in bit 0 and drops the old top bit.
- R5: Op 3'b011 (logical right) moves every bit down one place, puts 0 in the top bit and drops the old bit 0.
- R6: Op 3'b100 (rotate left) moves every bit up one place and puts the old top bit in bit 0.
- R7: Op 3'b101 (rotate right) moves every bit down one place and puts the old bit 0 in the top bit.
- R8: Op 3'b110 (arithmetic left) gives the same register value as the logical left shift.
- R9: Op 3'b111 (arithmetic right) keeps the sign bit. Each lower bit takes the old bit above it, and the old bit 0 is dropped.
- R10: After an arithmetic left shift, the overflow flag is 1 exactly when the old top two bits differ. Any other enabled op clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Lets the op take effect at this edge |
| op | input | 3 | Operation code |
| load_data | input | WIDTH | Parallel load value |
| data_out | output | WIDTH | Register contents |
| ovf | output | 1 | Registered sign-reversal flag |

## Verification
The bench uses a 4-bit copy of the block. For every one of the 16 starting values it loads the value and then applies each op code, so all end bits and both sign states are covered. The rotate cases show whether the bit shifted out really comes back in at the other end, which separates them from the logical shifts. Negative starting values separate the arithmetic right shift from the logical one. All four combinations of the top two bits are tried under arithmetic left, so the flag is checked both when it should rise and when it should stay low. Repeating the sweep with enable low shows that both the register and the flag hold their values.

// File: rtl/shift_uop_pkg.sv
package shift_uop_pkg;
    typedef enum logic [2:0] {
        OP_HOLD = 3'b000,
        OP_LOAD = 3'b001,
        OP_LSL  = 3'b010,
        OP_LSR  = 3'b011,
        OP_ROL  = 3'b100,
        OP_ROR  = 3'b101,
        OP_ASL  = 3'b110,
        OP_ASR  = 3'b111
    } shift_op_e;
endpackage

// File: rtl/shift_uop_unit.sv
module shift_uop_unit
    import shift_uop_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_data,
    output logic [WIDTH-1:0] nxt,
    output logic             sign_flip
);
    localparam int MSB = WIDTH - 1;

    logic up_fill;
    logic dn_fill;
    logic [WIDTH-1:0] up_val;
    logic [WIDTH-1:0] dn_val;

    // Fill bits for the shifted-in ends, chosen by op
    always_comb begin
        up_fill = 1'b0;
        dn_fill = 1'b0;
        if (op == OP_ROL) up_fill = cur[MSB];
        if (op == OP_ROR) dn_fill = cur[0];
        if (op == OP_ASR) dn_fill = cur[MSB];
    end

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            if (i == 0) begin : g_lo
                assign up_val[i] = up_fill;
            end else begin : g_up
                assign up_val[i] = cur[i-1];
            end
            if (i == MSB) begin : g_hi
                assign dn_val[i] = dn_fill;
            end else begin : g_dn
                assign dn_val[i] = cur[i+1];
            end
        end
    endgenerate

    always_comb begin
        unique case (shift_op_e'(op))
            OP_HOLD: nxt = cur;
            OP_LOAD: nxt = load_data;
            OP_LSL, OP_ROL, OP_ASL: nxt = up_val;
            default: nxt = dn_val;
        endcase
    end

    assign sign_flip = cur[MSB] ^ cur[MSB-1];
endmodule

// File: rtl/shift_uop_reg.sv
module shift_uop_reg
    import shift_uop_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] load_data,
    output logic [WIDTH-1:0] data_out,
    output logic             ovf
);
    typedef struct packed {
        logic [WIDTH-1:0] r;
        logic             ovf;
    } state_t;

    state_t st_d, st_q;
    logic [WIDTH-1:0] unit_nxt;
    logic             unit_flip;

    shift_uop_unit #(.WIDTH(WIDTH)) u_unit (
        .op        (op),
        .cur       (st_q.r),
        .load_data (load_data),
        .nxt       (unit_nxt),
        .sign_flip (unit_flip)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.r   = unit_nxt;
            st_d.ovf = (op == OP_ASL) ? unit_flip : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign data_out = st_q.r;
    assign ovf      = st_q.ovf;
endmodule

// File: rtl/shift_uop_chk.sv
module shift_uop_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [2:0]       op,
    input logic [WIDTH-1:0] load_data,
    input logic [WIDTH-1:0] data_out,
    input logic             ovf
);
    localparam int M = WIDTH - 1;

    assert_reset_R1: assert property (@(posedge clk) rst |=> (data_out == '0 && !ovf));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(data_out) && $stable(ovf)));
    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        (en && op == 3'b001) |=> data_out == $past(load_data));
    assert_rotl_R6: assert property (@(posedge clk) disable iff (rst)
        (en && op == 3'b100) |=> data_out == {$past(data_out[M-1:0]), $past(data_out[M])});
    assert_asr_sign_R9: assert property (@(posedge clk) disable iff (rst)
        (en && op == 3'b111) |=> data_out[M] == $past(data_out[M]));
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (en && op != 3'b110) |=> !ovf);
    assert_ovf_set_R10: assert property (@(posedge clk) disable iff (rst)
        (en && op == 3'b110) |=> ovf == (data_out[M] != $past(data_out[M])));
endmodule

bind shift_uop_reg shift_uop_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .en(en), .op(op),
    .load_data(load_data), .data_out(data_out), .ovf(ovf)
);

// File: tb/sim_shift_uop_reg.sv
`timescale 1ns/1ps
module sim_shift_uop_reg;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic [2:0]   op = 3'b000;
    logic [W-1:0] load_data = '0;
    logic [W-1:0] data_out;
    logic         ovf;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shift_uop_reg #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .en(en), .op(op),
        .load_data(load_data), .data_out(data_out), .ovf(ovf)
    );

    task automatic check(input string req, input logic [W-1:0] exp_r, input logic exp_o);
        checks++;
        if (data_out !== exp_r || ovf !== exp_o) begin
            fails++;
            $display("FAIL %s: got r=%b ovf=%b, expected r=%b ovf=%b",
                     req, data_out, ovf, exp_r, exp_o);
        end
    endtask

    // Drive inputs at the falling edge, then wait one rising edge and sample
    // again at the next falling edge.
    task automatic step(input logic e, input logic [2:0] o, input logic [W-1:0] d);
        en = e; op = o; load_data = d;
        @(negedge clk);
    endtask

    function automatic string req_of(input int o);
        case (o)
            0: return "R2";  1: return "R3";  2: return "R4";  3: return "R5";
            4: return "R6";  5: return "R7";  6: return "R8";  default: return "R9";
        endcase
    endfunction

    initial begin
        @(negedge clk);
        step(1'b0, 3'b000, '0);
        rst = 1'b0;
        check("R1", '0, 1'b0);
        for (int v = 0; v < 16; v++) begin
            for (int o = 0; o < 8; o++) begin
                logic [W-1:0] val, exp;
                logic eo;
                int u;
                val = v[W-1:0];
                step(1'b1, 3'b001, val);
                check("R3", val, 1'b0);
                // compute expected value arithmetically
                u = v;
                eo = 1'b0;
                case (o)
                    0: exp = val;
                    1: exp = 4'(~v);
                    2: exp = 4'((u * 2) % 16);
                    3: exp = 4'(u / 2);
                    4: exp = 4'(((u * 2) % 16) + (u / 8));
                    5: exp = 4'((u / 2) + (u % 2) * 8);
                    6: begin
                        exp = 4'((u * 2) % 16);
                        eo = ((u / 8) % 2) != ((u / 4) % 2);
                    end
                    default: exp = 4'((u / 2) + (u / 8) * 8);
                endcase
                step(1'b1, 3'(o), 4'(~v));
                check(o == 6 ? "R8/R10" : req_of(o), exp, eo);
                // disabled cycle holds value and flag
                step(1'b0, 3'(7 - o), 4'(v + 3));
                check("R2", exp, eo);
                // any other enabled op clears flag
                if (o == 6) begin
                    step(1'b1, 3'b000, '0);
                    check("R10", exp, 1'b0);
                end
            end
        end
        // reset mid-run after setting flag
        step(1'b1, 3'b001, 4'b0100);
        step(1'b1, 3'b110, '0);
        check("R10", 4'b1000, 1'b1);
        rst = 1'b1;
        step(1'b0, 3'b000, '0);
        rst = 1'b0;
        check("R1", '0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule